// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder for an 8-bit 8086-Family Bus

This block turns the address and control lines of an 8-bit-bus 8086-family processor into the active-low chip enables, output enables and write enables of two memory regions. A 32 KB boot EPROM bank sits at the top of the 1 MB space, F8000H to FFFFFH. The bank is built from eight 4 KB devices, and each device has its own chip enable. A 512 KB SRAM region fills the bottom half, 00000H to 7FFFFH.

The EPROM selects come from a 3-to-8 decode stage with one high-active enable and two low-active enables. Address bits A14..A12 pick the device. The high-active enable is the AND of A19..A15. One low-active enable is the I/O-cycle qualifier. The other low-active enable is the read qualifier.

The decode is purely combinational. It sits between the demultiplexed address lines and the memory devices. A select is asserted only during a memory cycle that has exactly one strobe active. When both strobes are low, the bus is treated as idle.

Top module: `mem_cs_decoder`

## Requirements
- R1: A memory read (io_cycle=0, rd_n=0, wr_n=1) at any address F8000H..FFFFFH drives rom_ce_n[A14:A12] low and rom_oe_n low. The other seven rom_ce_n bits and all three SRAM outputs stay high.
- R2: A memory read of the reset location FFFF0H selects EPROM device 7 (rom_ce_n = 8'b0111_1111).
- R3: A memory read at 00000H..7FFFFH (A19=0) drives sram_ce_n and sram_oe_n low. It keeps sram_we_n, rom_oe_n and every rom_ce_n bit high.
- R4: A memory write (io_cycle=0, wr_n=0, rd_n=1) at 00000H..7FFFFH drives sram_ce_n and sram_we_n low. It keeps sram_oe_n high and all EPROM outputs high.
- R5: A memory write at F8000H..FFFFFH asserts no output: all rom_ce_n bits, rom_oe_n and all SRAM outputs stay high.
- R6: Any memory read or write at 80000H..F7FFFH asserts no output.
- R7: While io_cycle=1, every output stays high, whatever the address and strobes.
- R8: With rd_n and wr_n both high (idle), or both low (illegal), every output stays high.
- R9: At no time is more than one device chip enable low across rom_ce_n and sram_ce_n. rom_oe_n is low only with rd_n low. sram_oe_n is low only with rd_n low. sram_we_n is low only with wr_n low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 20 | Demultiplexed processor address A19..A0 |
| io_cycle | input | 1 | 1 = I/O bus cycle, 0 = memory bus cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rom_ce_n | output | 8 | Active-low chip enables, one per 4 KB EPROM; bit i covers F8000H + i*1000H |
| rom_oe_n | output | 1 | Active-low output enable shared by the EPROM bank |
| sram_ce_n | output | 1 | Active-low SRAM region chip enable |
| sram_oe_n | output | 1 | Active-low SRAM output enable |
| sram_we_n | output | 1 | Active-low SRAM write enable |

## Verification
The assertions assume that the address, io_cycle and strobe inputs hold settled, two-state values whenever the outputs are sampled. They also assume that the relations hold on settled combinational values, never on intermediate evaluations.

The bench changes all inputs together on the falling clock edge and samples one nanosecond later. The checks therefore only ever see a settled decode. The illegal state with both strobes low is driven on purpose, so that its all-inactive result is observed at the ports.

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder #(
  parameter int ADDR_W    = 20,
  parameter int ROM_SEL_W = 3,
  parameter int ROM_DEV_W = 12
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       io_cycle,
  input  logic                       rd_n,
  input  logic                       wr_n,
  output logic [(1<<ROM_SEL_W)-1:0]  rom_ce_n,
  output logic                       rom_oe_n,
  output logic                       sram_ce_n,
  output logic                       sram_oe_n,
  output logic                       sram_we_n
);
  localparam int ROM_N   = 1 << ROM_SEL_W;
  localparam int BANK_LO = ROM_DEV_W + ROM_SEL_W;

  logic rd_act, wr_act, mem_act;
  logic en_hi, en_lo_a_n, en_lo_b_n, stage_on;
  logic [ROM_SEL_W-1:0] rom_idx;

  assign rd_act  = ~rd_n &  wr_n;
  assign wr_act  =  rd_n & ~wr_n;
  assign mem_act = ~io_cycle & (rd_act | wr_act);

  // 3-to-8 stage: one high-active enable, two low-active enables
  assign en_hi     = &addr[ADDR_W-1:BANK_LO];
  assign en_lo_a_n = io_cycle;
  assign en_lo_b_n = ~rd_act;
  assign stage_on  = en_hi & ~en_lo_a_n & ~en_lo_b_n;
  assign rom_idx   = addr[BANK_LO-1:ROM_DEV_W];

  for (genvar i = 0; i < ROM_N; i++) begin : g_rom_sel
    assign rom_ce_n[i] = ~(stage_on && (rom_idx == ROM_SEL_W'(i)));
  end

  assign rom_oe_n  = (&rom_ce_n) | rd_n;

  assign sram_ce_n = ~(mem_act & ~addr[ADDR_W-1]);
  assign sram_oe_n = sram_ce_n | rd_n;
  assign sram_we_n = sram_ce_n | wr_n;
endmodule

module mem_cs_decoder_chk #(
  parameter int ADDR_W    = 20,
  parameter int ROM_SEL_W = 3
) (
  input logic [ADDR_W-1:0]         addr,
  input logic                      io_cycle,
  input logic                      rd_n,
  input logic                      wr_n,
  input logic [(1<<ROM_SEL_W)-1:0] rom_ce_n,
  input logic                      rom_oe_n,
  input logic                      sram_ce_n,
  input logic                      sram_oe_n,
  input logic                      sram_we_n
);
  logic all_idle;
  assign all_idle = (&rom_ce_n) & rom_oe_n & sram_ce_n & sram_oe_n & sram_we_n;

  always_comb begin
    // R9
    one_device_chk: assert ($onehot0(~{rom_ce_n, sram_ce_n}));
    // R9
    rom_oe_rd_chk: assert (rom_oe_n || !rd_n);
    // R9
    sram_we_wr_chk: assert (sram_we_n || !wr_n);
    // R9
    sram_oe_rd_chk: assert (sram_oe_n || !rd_n);
    // R7
    io_quiet_chk: assert (!io_cycle || all_idle);
    // R8
    strobe_pair_chk: assert ((rd_n ^ wr_n) || all_idle);
    // R5
    rom_wr_quiet_chk: assert (wr_n || ((&rom_ce_n) && rom_oe_n));
    // R3
    sram_low_half_chk: assert (sram_ce_n || !addr[ADDR_W-1]);
    // R6
    hole_quiet_chk: assert (!(addr[ADDR_W-1] && !(&addr[ADDR_W-2:ADDR_W-5])) || all_idle);
  end
endmodule

bind mem_cs_decoder mem_cs_decoder_chk #(.ADDR_W(ADDR_W), .ROM_SEL_W(ROM_SEL_W)) i_chk (.*);

// File: tb/test_mem_cs_decoder.sv
module test_mem_cs_decoder;
  logic clk = 0;
  logic rst = 1;
  always #2 clk = ~clk;

  logic [19:0] addr = '0;
  logic io_cycle = 0, rd_n = 1, wr_n = 1;
  logic [7:0] rom_ce_n;
  logic rom_oe_n, sram_ce_n, sram_oe_n, sram_we_n;

  int checks = 0, failures = 0;
  bit done = 0;

  mem_cs_decoder i_mem_cs_decoder (.*);

  // {rom_ce_n[7:0], rom_oe_n, sram_ce_n, sram_oe_n, sram_we_n}
  localparam logic [11:0] IDLE = 12'hFFF;

  task automatic apply(input logic [19:0] a, input logic io, input logic r, input logic w);
    @(negedge clk);
    addr = a; io_cycle = io; rd_n = r; wr_n = w;
    #1;
  endtask

  task automatic check(input string req, input logic [11:0] exp);
    logic [11:0] got;
    got = {rom_ce_n, rom_oe_n, sram_ce_n, sram_oe_n, sram_we_n};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s addr=%05h io=%0b rd_n=%0b wr_n=%0b got=%03h exp=%03h",
               req, addr, io_cycle, rd_n, wr_n, got, exp);
    end
  endtask

  task automatic t_reset_idle();
    apply(20'h00000, 0, 1, 1);
    check("R8 idle after reset", IDLE);
  endtask

  task automatic t_rom_reads();
    for (int d = 0; d < 8; d++) begin
      logic [7:0] ce;
      ce = ~(8'd1 << d);
      apply(20'hF8000 | (20'(d) << 12), 0, 0, 1);
      check("R1 rom read low", {ce, 1'b0, 3'b111});
      apply(20'hF8FFF | (20'(d) << 12), 0, 0, 1);
      check("R1 rom read high", {ce, 1'b0, 3'b111});
    end
  endtask

  task automatic t_reset_vector();
    apply(20'hFFFF0, 0, 0, 1);
    check("R2 reset vector", {8'b0111_1111, 1'b0, 3'b111});
  endtask

  task automatic t_sram_read();
    logic [19:0] al [3] = '{20'h00000, 20'h12345, 20'h7FFFF};
    foreach (al[k]) begin
      apply(al[k], 0, 0, 1);
      check("R3 sram read", {8'hFF, 1'b1, 3'b001});
    end
  endtask

  task automatic t_sram_write();
    logic [19:0] al [3] = '{20'h00000, 20'h4ABCD, 20'h7FFFF};
    foreach (al[k]) begin
      apply(al[k], 0, 1, 0);
      check("R4 sram write", {8'hFF, 1'b1, 3'b010});
    end
  endtask

  task automatic t_rom_write();
    apply(20'hF8000, 0, 1, 0); check("R5 rom write", IDLE);
    apply(20'hFFFF0, 0, 1, 0); check("R5 rom write vector", IDLE);
  endtask

  task automatic t_holes();
    logic [19:0] al [4] = '{20'h80000, 20'hC0000, 20'hF7FFF, 20'hF0000};
    foreach (al[k]) begin
      apply(al[k], 0, 0, 1); check("R6 hole read", IDLE);
      apply(al[k], 0, 1, 0); check("R6 hole write", IDLE);
    end
  endtask

  task automatic t_io();
    apply(20'hFFFF0, 1, 0, 1); check("R7 io read top", IDLE);
    apply(20'h00010, 1, 0, 1); check("R7 io read low", IDLE);
    apply(20'h00010, 1, 1, 0); check("R7 io write low", IDLE);
  endtask

  task automatic t_strobes();
    apply(20'hFFFF0, 0, 0, 0); check("R8 both low rom", IDLE);
    apply(20'h01000, 0, 0, 0); check("R8 both low sram", IDLE);
    apply(20'hF9000, 0, 1, 1); check("R8 both high rom", IDLE);
  endtask

  task automatic t_exclusive();
    apply(20'h7FFFF, 0, 0, 1);
    checks++;
    if ($countones(~{rom_ce_n, sram_ce_n}) != 1) begin
      failures++;
      $display("FAIL R9 selects=%0d exp=1", $countones(~{rom_ce_n, sram_ce_n}));
    end
    apply(20'hF8000, 0, 0, 1);
    checks++;
    if ($countones(~{rom_ce_n, sram_ce_n}) != 1) begin
      failures++;
      $display("FAIL R9 selects=%0d exp=1", $countones(~{rom_ce_n, sram_ce_n}));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    t_reset_idle();
    t_rom_reads();
    t_reset_vector();
    t_sram_read();
    t_sram_write();
    t_rom_write();
    t_holes();
    t_io();
    t_strobes();
    t_exclusive();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule